// File: doc/BRIEF.md
# Two-Wire Serial Slave Register Port

This block is the serial slave that lets a bus master on a two-wire bus (one clock line, one bidirectional data line) read and write the configuration registers of a synthesizer. It runs on the chip's system clock, oversamples both bus lines through two-flop synchronisers, and finds START, STOP and clock edges from the synchronised samples. The data line is open-drain: the block never drives a one. It raises `sdaOe` when it wants the line pulled low.

A transfer begins with a control byte: a fixed four-bit code `1011`, a three-bit device address and a direction bit (0 = write, 1 = read). The stored device address resets to `000` and can be rewritten over the bus. A write transfer carries a command byte that picks a register, followed by data bytes. A read transfer returns the register picked by the most recent command. Two registers are implemented. Command `0Dh` reaches the 3-bit device address. Command `37h` reaches a 14-bit range value, which is sent over two bytes with the most significant byte first.

Top module: `twowire_slave`

## Requirements
- R1: After reset, `devAddr` is 000, `rangeVal` is 0 and `sdaOe` is 0.
- R2: The block pulls the data line low during the ninth clock only when the control byte has bits 7:4 equal to 1011 and bits 3:1 equal to `devAddr`. For any other control byte it releases the line for the rest of the transfer.
- R3: In a write transfer, the block acknowledges the control byte, the command byte and every data byte.
- R4: After command 37h, the first data byte written goes to range bits 13:6. The second data byte's bits 7:2 go to range bits 5:0, and its bits 1:0 are ignored. Further bytes continue to alternate between the upper part and the lower part.
- R5: A read after command 37h returns range bits 13:6 first. The next byte is {range bits 5:0, 00}. Later bytes alternate between these two.
- R6: After command 0Dh, bits 2:0 of a written data byte become `devAddr`. Later control bytes must match the new address, and the old address gets no acknowledge. A read after command 0Dh returns {00000, devAddr}.
- R7: A STOP or a repeated START at any point ends the transfer and returns the block to waiting for a control byte. A partly received byte changes no register.
- R8: When the master does not acknowledge a read byte, the block releases the data line and drives nothing more until the next START.
- R9: `sdaOe`, `devAddr` and `rangeVal` change only while SCL is low.
- R10: Data bytes written after a command other than 0Dh or 37h are acknowledged and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sdaOe | output | 1 | 1 = pull the data line low |
| devAddr | output | 3 | Stored device address |
| rangeVal | output | 14 | 14-bit range register |

## Verification
The assertions check two things on every cycle. First, the reset values. Second, that the pull-down and both register outputs change only while the bus clock is low, which keeps the slave from ever creating a false START or STOP. Only the bench scenarios can show the rest: address matching, command decoding, the way register bytes are split and ordered, acknowledges, aborts by STOP or repeated START, and the release after a master NACK. The bench drives whole bus transfers and compares the register outputs against a behavioural model during every SCL-high phase.

// File: rtl/twowire_pkg.sv
package twowire_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_CMD, ST_WDATA, ST_RDATA, ST_SKIP
  } busState_t;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic shiftIn;    // sample one received bit
    logic takeCmd;    // received byte is the command
    logic writeByte;  // received byte is data for the selected register
    logic startRead;  // read transfer accepted, restart byte order
    logic loadTx;     // load next read byte
    logic shiftTx;    // advance to next read bit
  } dpStrobe_t;
endpackage

// File: rtl/twowire_regs.sv
module twowire_regs
  import twowire_pkg::*;
#(
  parameter int VAL_W = 14,
  parameter logic [3:0] CTRL_CODE = 4'b1011,
  parameter logic [7:0] CMD_ADDR = 8'h0D,
  parameter logic [7:0] CMD_RANGE = 8'h37
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobe_t strobe,
  input  logic sdaBit,
  output logic ctrlMatch,
  output logic ctrlRead,
  output logic txMsb,
  output logic [2:0] devAddr,
  output logic [VAL_W-1:0] rangeVal
);
  localparam int LOW_W = VAL_W - 8;
  localparam int PAD = 8 - LOW_W;

  logic [7:0] rxShift;
  logic [7:0] cmdReg;
  logic [7:0] txShift;
  logic [7:0] readByte;
  logic byteOdd;

  always_comb begin
    readByte = 8'h00;
    if (cmdReg == CMD_ADDR) readByte = {5'b00000, devAddr};
    else if (cmdReg == CMD_RANGE)
      readByte = byteOdd ? {rangeVal[LOW_W-1:0], {PAD{1'b0}}} : rangeVal[VAL_W-1:LOW_W];
  end

  assign ctrlMatch = (rxShift[7:4] == CTRL_CODE) && (rxShift[3:1] == devAddr);
  assign ctrlRead = rxShift[0];
  assign txMsb = txShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      cmdReg <= '0;
      txShift <= '0;
      byteOdd <= 1'b0;
      devAddr <= '0;
      rangeVal <= '0;
    end else begin
      if (strobe.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (strobe.takeCmd) cmdReg <= rxShift;
      if (strobe.takeCmd || strobe.startRead) byteOdd <= 1'b0;
      else if (strobe.writeByte || strobe.loadTx) byteOdd <= ~byteOdd;
      if (strobe.writeByte) begin
        if (cmdReg == CMD_ADDR) devAddr <= rxShift[2:0];
        else if (cmdReg == CMD_RANGE) begin
          if (!byteOdd) rangeVal[VAL_W-1:LOW_W] <= rxShift;
          else rangeVal[LOW_W-1:0] <= rxShift[7:PAD];
        end
      end
      if (strobe.loadTx) txShift <= readByte;
      else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/twowire_ctrl.sv
module twowire_ctrl
  import twowire_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic ctrlMatch,
  input  logic ctrlRead,
  input  logic txMsb,
  output dpStrobe_t strobe,
  output logic sdaBit,
  output logic sdaOe
);
  logic sclMeta, sclNow, sclPrev;
  logic sdaMeta, sdaNow, sdaPrev;
  busState_t state;
  logic [3:0] bitCnt;
  logic ackPhase, ackDrive, txOn, mAck;

  wire sclRise = sclNow & ~sclPrev;
  wire sclFall = ~sclNow & sclPrev;
  wire startCond = sclNow & sclPrev & sdaPrev & ~sdaNow;
  wire stopCond = sclNow & sclPrev & ~sdaPrev & sdaNow;
  wire active = (state != ST_IDLE) && (state != ST_SKIP);
  wire byteEnd = sclFall && active && !ackPhase && (bitCnt == 4'd8);

  assign sdaBit = sdaNow;
  assign sdaOe = ackDrive | (txOn & ~txMsb);

  always_comb begin
    strobe = '0;
    strobe.shiftIn = sclRise && !ackPhase && (bitCnt < 4'd8) &&
                     (state inside {ST_CTRL, ST_CMD, ST_WDATA});
    strobe.takeCmd = byteEnd && (state == ST_CMD);
    strobe.writeByte = byteEnd && (state == ST_WDATA);
    strobe.startRead = byteEnd && (state == ST_CTRL) && ctrlMatch && ctrlRead;
    strobe.loadTx = sclFall && ackPhase && (state == ST_RDATA) && mAck;
    strobe.shiftTx = sclFall && !ackPhase && (state == ST_RDATA) &&
                     (bitCnt != 4'd0) && (bitCnt < 4'd8);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {sclMeta, sclNow, sclPrev} <= 3'b111;
      {sdaMeta, sdaNow, sdaPrev} <= 3'b111;
    end else begin
      {sclMeta, sclNow, sclPrev} <= {sclIn, sclMeta, sclNow};
      {sdaMeta, sdaNow, sdaPrev} <= {sdaIn, sdaMeta, sdaNow};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      ackPhase <= 1'b0;
      ackDrive <= 1'b0;
      txOn <= 1'b0;
      mAck <= 1'b0;
    end else if (startCond || stopCond) begin
      state <= startCond ? ST_CTRL : ST_IDLE;
      bitCnt <= '0;
      ackPhase <= 1'b0;
      ackDrive <= 1'b0;
      txOn <= 1'b0;
    end else if (active) begin
      if (sclRise) begin
        if (ackPhase) mAck <= ~sdaNow;
        else if (bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
      end
      if (sclFall) begin
        if (ackPhase) begin
          ackPhase <= 1'b0;
          bitCnt <= '0;
          ackDrive <= 1'b0;
          if (state == ST_RDATA) begin
            txOn <= mAck;
            if (!mAck) state <= ST_SKIP;
          end
        end else if (bitCnt == 4'd8) begin
          ackPhase <= 1'b1;
          txOn <= 1'b0;
          case (state)
            ST_CTRL: begin
              if (ctrlMatch) begin
                ackDrive <= 1'b1;
                mAck <= 1'b1;
                state <= ctrlRead ? ST_RDATA : ST_CMD;
              end else state <= ST_SKIP;
            end
            ST_CMD: begin
              ackDrive <= 1'b1;
              state <= ST_WDATA;
            end
            ST_WDATA: ackDrive <= 1'b1;
            default: ackDrive <= 1'b0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/twowire_slave.sv
module twowire_slave
  import twowire_pkg::*;
#(
  parameter int VAL_W = 14,
  parameter logic [3:0] CTRL_CODE = 4'b1011,
  parameter logic [7:0] CMD_ADDR = 8'h0D,
  parameter logic [7:0] CMD_RANGE = 8'h37
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  output logic [2:0] devAddr,
  output logic [VAL_W-1:0] rangeVal
);
  dpStrobe_t strobe;
  logic sdaBit, ctrlMatch, ctrlRead, txMsb;

  twowire_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctrlMatch(ctrlMatch), .ctrlRead(ctrlRead), .txMsb(txMsb),
    .strobe(strobe), .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  twowire_regs #(
    .VAL_W(VAL_W), .CTRL_CODE(CTRL_CODE), .CMD_ADDR(CMD_ADDR), .CMD_RANGE(CMD_RANGE)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit),
    .ctrlMatch(ctrlMatch), .ctrlRead(ctrlRead), .txMsb(txMsb),
    .devAddr(devAddr), .rangeVal(rangeVal)
  );
endmodule

// File: rtl/twowire_slave_chk.sv
module twowire_slave_chk #(
  parameter int VAL_W = 14
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic [2:0] devAddr,
  input logic [VAL_W-1:0] rangeVal
);
  // R1: reset values visible on the first cycle out of reset
  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (devAddr == 3'd0 && rangeVal == '0 && !sdaOe));

  // R9: pull-down only moves while the bus clock is low
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R9 / R4: range register only written while the bus clock is low
  a_r9_range_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rangeVal) |-> !sclIn);

  // R9 / R6: address register only written while the bus clock is low
  a_r9_addr_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devAddr) |-> !sclIn);
endmodule

bind twowire_slave twowire_slave_chk #(.VAL_W(VAL_W)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .devAddr(devAddr), .rangeVal(rangeVal)
);

// File: tb/sim_twowire_slave.sv
`timescale 1ns/1ps
module sim_twowire_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic [2:0] devAddr;
  logic [13:0] rangeVal;
  wire sdaBus = sdaM & ~sdaOe;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int sclHigh = 0;
  logic [2:0] mAddr = 3'd0;
  logic [13:0] mRange = 14'd0;

  always #2.5 clk = ~clk;

  twowire_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .devAddr(devAddr), .rangeVal(rangeVal)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model compared while the bus clock is steadily high (R4 R6 R7 R10)
  always @(negedge clk) begin
    if (rstN && scl) sclHigh++;
    else sclHigh = 0;
    if (sclHigh >= 4) begin
      chk(devAddr == mAddr, "R6 model devAddr", devAddr, mAddr);
      chk(rangeVal == mRange, "R4 R7 R10 model rangeVal", rangeVal, mRange);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitClk(input logic b, output logic s);
    sdaM = b; waitQ();
    scl = 1'b1; waitQ();
    s = sdaBus; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic send8(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) bitClk(b[i], s);
  endtask

  task automatic ackSlot(output logic a);
    logic s;
    bitClk(1'b1, s);
    a = ~s;
  endtask

  task automatic putByte(input logic [7:0] b, output logic a);
    send8(b);
    ackSlot(a);
  endtask

  task automatic getByte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitClk(1'b1, s);
      d[i] = s;
    end
    bitClk(~mack, s);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    logic s;
    int relCount;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(devAddr == 3'd0, "R1 devAddr reset", devAddr, 0);
    chk(rangeVal == 14'd0, "R1 rangeVal reset", rangeVal, 0);
    chk(sdaOe == 1'b0, "R1 sdaOe reset", sdaOe, 0);

    // range write: 37h, A5 then 3C -> {A5, 001111}
    busStart();
    putByte(8'hB0, a); chk(a, "R2 R3 ack control write", a, 1);
    putByte(8'h37, a); chk(a, "R3 ack command", a, 1);
    send8(8'hA5); mRange[13:6] = 8'hA5;
    ackSlot(a); chk(a, "R3 ack data 1", a, 1);
    send8(8'h3C); mRange[5:0] = 6'b001111;
    ackSlot(a); chk(a, "R3 ack data 2", a, 1);
    busStop();
    chk(rangeVal == 14'h294F, "R4 range after write", rangeVal, 14'h294F);

    // range read: high, low, high again, then NACK
    busStart();
    putByte(8'hB1, a); chk(a, "R2 ack control read", a, 1);
    getByte(1'b1, d); chk(d == 8'hA5, "R5 read byte 1", d, 8'hA5);
    getByte(1'b1, d); chk(d == 8'h3C, "R5 read byte 2", d, 8'h3C);
    getByte(1'b0, d); chk(d == 8'hA5, "R5 read byte 3 alternates", d, 8'hA5);
    relCount = 0;
    for (int i = 0; i < 9; i++) begin
      bitClk(1'b1, s);
      if (s) relCount++;
    end
    chk(relCount == 9, "R8 released after NACK", relCount, 9);
    busStop();

    // wrong code and wrong address get no acknowledge
    busStart();
    putByte(8'hA0, a); chk(!a, "R2 wrong code no ack", a, 0);
    putByte(8'h37, a); chk(!a, "R2 silent after wrong code", a, 0);
    busStop();
    busStart();
    putByte(8'hB2, a); chk(!a, "R2 wrong address no ack", a, 0);
    busStop();

    // rewrite address to 5
    busStart();
    putByte(8'hB0, a); chk(a, "R6 ack old address", a, 1);
    putByte(8'h0D, a); chk(a, "R6 ack address command", a, 1);
    send8(8'hF5); mAddr = 3'd5;
    ackSlot(a); chk(a, "R6 ack address data", a, 1);
    busStop();
    chk(devAddr == 3'd5, "R6 devAddr updated", devAddr, 5);
    busStart();
    putByte(8'hB0, a); chk(!a, "R6 old address ignored", a, 0);
    busStop();
    busStart();
    putByte(8'hBA, a); chk(a, "R6 new address matched", a, 1);
    putByte(8'h0D, a); chk(a, "R6 ack command", a, 1);
    busStart();
    putByte(8'hBB, a); chk(a, "R7 ack after repeated START", a, 1);
    getByte(1'b0, d); chk(d == 8'h05, "R6 read address", d, 8'h05);
    busStop();

    // abort by STOP inside a data byte
    busStart();
    putByte(8'hBA, a);
    putByte(8'h37, a);
    for (int i = 0; i < 4; i++) bitClk(1'b0, s);
    busStop();
    chk(rangeVal == 14'h294F, "R7 partial byte discarded on STOP", rangeVal, 14'h294F);

    // abort by repeated START inside a data byte, then a full write
    busStart();
    putByte(8'hBA, a);
    putByte(8'h37, a);
    for (int i = 0; i < 3; i++) bitClk(1'b1, s);
    busStart();
    putByte(8'hBA, a); chk(a, "R7 control after abort", a, 1);
    chk(rangeVal == 14'h294F, "R7 partial byte discarded on START", rangeVal, 14'h294F);
    putByte(8'h37, a);
    send8(8'h12); mRange[13:6] = 8'h12;
    ackSlot(a);
    send8(8'h40); mRange[5:0] = 6'b010000;
    ackSlot(a);
    busStop();
    chk(rangeVal == 14'h0490, "R4 range second write", rangeVal, 14'h0490);

    // unknown command: acked, nothing changes
    busStart();
    putByte(8'hBA, a);
    putByte(8'h44, a); chk(a, "R10 ack unknown command", a, 1);
    putByte(8'h77, a); chk(a, "R10 ack data to unknown", a, 1);
    busStop();
    chk(rangeVal == 14'h0490 && devAddr == 3'd5, "R10 registers unchanged",
        {devAddr, rangeVal}, {3'd5, 14'h0490});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule